// File: doc/BRIEF.md
# Inter-Processor Interrupt Queue Controller

This block lets the cores of a multi-core cluster signal one another. Each core owns a first-in first-out queue of pending interrupt numbers and a single interrupt line toward it. A core raises an interrupt by writing one word to a send register. The upper half of the word holds the interrupt number and the lower half names a core. One send register delivers to the named core alone. The other delivers to every core except the named one.

A core services its interrupts through a shared receive register. Each read of that register returns the oldest entry of the requesting core's own queue and removes it. Writing the receive register empties that core's queue. The requesting core is identified by a sideband field that travels with every bus access. A queue that runs empty reads back as zero, so interrupt number 0 is reserved and is never sent.

Each queue has a fixed depth. A delivery to a full queue is dropped and raises a sticky per-core overflow flag, which software reads and clears through a fourth register.

Top module: `ipiq_ctrl`

## Requirements
- R1: After reset every interrupt line is low, every queue is empty, the overflow register reads 0, and `bus_rdata` is 0.
- R2: A write to address 0 (send to one) takes the interrupt number from `bus_wdata[31:16]` and the target core from `bus_wdata[15:0]`. It appends the number to that target's queue only. A target index at or above the core count reaches no queue.
- R3: A write to address 1 (send to others) appends the number from `bus_wdata[31:16]` to every queue except that of the core named in `bus_wdata[15:0]`. If that index names no core, every queue receives the number.
- R4: A core's interrupt line is high in the cycle after the clock edge that accepts a delivery to its queue.
- R5: A read of address 2 (receive) removes the oldest entry of the queue selected by `bus_core` and returns it, zero-extended, on `bus_rdata` in the cycle after the accepting edge. Entries leave each queue in arrival order.
- R6: A read of address 2 when the requesting core's queue is empty returns 0 and changes no queue.
- R7: A write of any data to address 2 discards every entry of the queue selected by `bus_core`. Other queues keep their entries.
- R8: A core's interrupt line goes low in the cycle after a pop or flush leaves its queue empty, and it stays high while entries remain.
- R9: A delivery to a queue that already holds DEPTH entries is dropped. The queue keeps its existing entries and order, and that core's overflow flag is set and stays set.
- R10: A read of address 3 returns the overflow flags with bit i for core i. A write to address 3 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 untouched.
- R11: `bus_rdata` is 0 in every cycle that does not directly follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access is presented this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register select: 0 send-one, 1 send-others, 2 receive, 3 overflow |
| bus_core | input | CORE_W | Index of the requesting core |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | N_CORES | Per-core interrupt line, high while its queue is non-empty |

## Verification
Every result of this block becomes visible one cycle after the clock edge that accepts the access. Queue contents, interrupt lines, overflow flags and the receive data all update at that edge. The bench drives each access for one cycle. Right after the accepting edge, it advances a queue-based reference model. At the following falling edge it compares every interrupt line and `bus_rdata` with the model. Idle cycles get the same comparison, which keeps the zero-read rule and the sticky state covered between accesses.

// File: rtl/ipiq_pkg.sv
package ipiq_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_W  = 16;
  localparam int TGT_W  = 16;

  typedef enum logic [1:0] {
    REG_SEND_ONE    = 2'd0,
    REG_SEND_OTHERS = 2'd1,
    REG_RECV        = 2'd2,
    REG_OVF         = 2'd3
  } ipiq_reg_e;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_RECV = 2'd1,
    RSEL_OVF  = 2'd2
  } ipiq_rsel_e;

endpackage

// File: rtl/ipiq_fifo.sv
module ipiq_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && !full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      dout   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (pop)     dout   <= do_pop ? mem[rd_ptr] : '0;
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

endmodule

// File: rtl/ipiq_decode.sv
module ipiq_decode
  import ipiq_pkg::*;
#(
  parameter int N_CORES = 4,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_addr,
  input  logic [CORE_W-1:0] bus_core,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [N_CORES-1:0] push_vec,
  output logic [N_CORES-1:0] pop_vec,
  output logic [N_CORES-1:0] flush_vec,
  output logic [N_CORES-1:0] ovf_clr,
  output logic [NUM_W-1:0]  send_num,
  output logic              rd_recv,
  output logic              rd_ovf
);

  logic [TGT_W-1:0] target;
  logic             wr_one, wr_others, acc_recv;

  assign target    = bus_wdata[TGT_W-1:0];
  assign send_num  = bus_wdata[DATA_W-1:DATA_W-NUM_W];
  assign wr_one    = bus_valid && bus_write && (bus_addr == REG_SEND_ONE);
  assign wr_others = bus_valid && bus_write && (bus_addr == REG_SEND_OTHERS);
  assign acc_recv  = bus_valid && (bus_addr == REG_RECV);
  assign rd_recv   = acc_recv && !bus_write;
  assign rd_ovf    = bus_valid && !bus_write && (bus_addr == REG_OVF);
  assign ovf_clr   = (bus_valid && bus_write && (bus_addr == REG_OVF))
                     ? bus_wdata[N_CORES-1:0] : '0;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    logic hit, mine;
    assign hit          = (target == TGT_W'(i));
    assign mine         = (bus_core == CORE_W'(i));
    assign push_vec[i]  = (wr_one && hit) || (wr_others && !hit);
    assign pop_vec[i]   = acc_recv && !bus_write && mine;
    assign flush_vec[i] = acc_recv && bus_write && mine;
  end

endmodule

// File: rtl/ipiq_ctrl.sv
module ipiq_ctrl
  import ipiq_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DEPTH   = 4,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [1:0]         bus_addr,
  input  logic [CORE_W-1:0]  bus_core,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [N_CORES-1:0] irq_out
);

  logic [N_CORES-1:0] push_vec, pop_vec, flush_vec, ovf_clr;
  logic [N_CORES-1:0] q_empty, q_full;
  logic [NUM_W-1:0]   send_num;
  logic               rd_recv, rd_ovf;
  logic [NUM_W-1:0]   q_dout [N_CORES];

  logic [N_CORES-1:0] ovf_q, ovf_rd_q;
  ipiq_rsel_e         rsel_q;
  logic [CORE_W-1:0]  rcore_q;

  ipiq_decode #(.N_CORES(N_CORES)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_core  (bus_core),
    .bus_wdata (bus_wdata),
    .push_vec  (push_vec),
    .pop_vec   (pop_vec),
    .flush_vec (flush_vec),
    .ovf_clr   (ovf_clr),
    .send_num  (send_num),
    .rd_recv   (rd_recv),
    .rd_ovf    (rd_ovf)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : g_q
    ipiq_fifo #(.DEPTH(DEPTH), .WIDTH(NUM_W)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push_vec[i]),
      .din   (send_num),
      .pop   (pop_vec[i]),
      .flush (flush_vec[i]),
      .dout  (q_dout[i]),
      .empty (q_empty[i]),
      .full  (q_full[i])
    );

    always_ff @(posedge clk) begin
      if (rst)                          ovf_q[i] <= 1'b0;
      else if (push_vec[i] && q_full[i]) ovf_q[i] <= 1'b1;
      else if (ovf_clr[i])               ovf_q[i] <= 1'b0;
    end

    assign irq_out[i] = !q_empty[i];

    a_r4_irq_after_delivery: assert property (@(posedge clk) disable iff (rst)
      push_vec[i] |=> irq_out[i]);

    a_r8_irq_low_after_flush: assert property (@(posedge clk) disable iff (rst)
      flush_vec[i] |=> !irq_out[i]);

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
      (push_vec[i] && q_full[i]) |=> ovf_q[i]);

    a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
      (pop_vec[i] && !irq_out[i]) |=> (bus_rdata == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q   <= RSEL_NONE;
      rcore_q  <= '0;
      ovf_rd_q <= '0;
    end else begin
      rsel_q   <= rd_recv ? RSEL_RECV : (rd_ovf ? RSEL_OVF : RSEL_NONE);
      rcore_q  <= bus_core;
      ovf_rd_q <= ovf_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (rsel_q)
      RSEL_RECV: bus_rdata = {{(32 - NUM_W){1'b0}}, q_dout[rcore_q]};
      RSEL_OVF:  bus_rdata[N_CORES-1:0] = ovf_rd_q;
      default:   bus_rdata = '0;
    endcase
  end

  a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> (bus_rdata == '0));

endmodule

// File: tb/ipiq_ctrl_bench.sv
module ipiq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [1:0]    bus_addr  = 2'd0;
  logic [1:0]    bus_core  = 2'd0;
  logic [31:0]   bus_wdata = 32'd0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  int q [NC][$];
  logic [NC-1:0] m_ovf = '0;
  logic [31:0]   exp_rd = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipiq_ctrl #(.N_CORES(NC), .DEPTH(DP)) u_ipiq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_core  (bus_core),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic compare(input string tag);
    logic [NC-1:0] exp_irq;
    for (int i = 0; i < NC; i++) exp_irq[i] = (q[i].size() > 0);
    n_checks++;
    if (bus_rdata !== exp_rd) begin
      n_fail++;
      $display("FAIL %s rdata actual %h expected %h", tag, bus_rdata, exp_rd);
    end
    n_checks++;
    if (irq_out !== exp_irq) begin
      n_fail++;
      $display("FAIL %s irq actual %b expected %b", tag, irq_out, exp_irq);
    end
  endtask

  // one bus access (or an idle cycle when valid is 0), model, then compare
  task automatic access(input logic v, input logic w, input logic [1:0] a,
                        input int core, input logic [31:0] d, input string tag);
    int num, tgt;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a;
    bus_core = 2'(core); bus_wdata = d;
    @(posedge clk);
    num = int'(d[31:16]);
    tgt = int'(d[15:0]);
    exp_rd = '0;
    if (v) begin
      case (a)
        2'd0, 2'd1: for (int i = 0; i < NC; i++) begin
          if ((a == 2'd0 && i == tgt) || (a == 2'd1 && i != tgt)) begin
            if (q[i].size() < DP) q[i].push_back(num);
            else m_ovf[i] = 1'b1;
          end
        end
        2'd2: if (w) q[core].delete();
              else if (q[core].size() > 0) exp_rd = 32'(q[core].pop_front());
        default: if (w) m_ovf = m_ovf & ~d[NC-1:0];
                 else exp_rd = {{(32 - NC){1'b0}}, m_ovf};
      endcase
    end
    @(negedge clk);
    bus_valid = 1'b0;
    compare(tag);
  endtask

  function automatic logic [31:0] pk(input int num, input int tgt);
    return {16'(num), 16'(tgt)};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 during reset");
    rst = 1'b0;
    access(0, 0, 2'd0, 0, 0, "R1 idle after reset");
    access(1, 0, 2'd3, 0, 0, "R1 overflow reads 0");
    access(1, 0, 2'd2, 1, 0, "R1 R6 empty read");

    // unicast
    access(1, 1, 2'd0, 0, pk(5, 2), "R2 R4 unicast to 2");
    access(1, 0, 2'd2, 0, 0, "R2 other core empty");
    access(1, 1, 2'd0, 0, pk(9, 7), "R2 out-of-range target");
    access(0, 0, 2'd0, 0, 0, "R11 idle");
    access(1, 0, 2'd2, 2, 0, "R5 R8 pop core 2");
    access(1, 0, 2'd2, 2, 0, "R6 pop empty core 2");

    // broadcast
    access(1, 1, 2'd1, 3, pk(7, 1), "R3 R4 others except 1");
    access(1, 0, 2'd2, 1, 0, "R3 excluded core empty");
    for (int c = 0; c < NC; c++) access(1, 0, 2'd2, c, 0, "R3 R5 drain");
    access(1, 1, 2'd1, 0, pk(8, 100), "R3 others out-of-range");
    for (int c = NC - 1; c >= 0; c--) access(1, 0, 2'd2, c, 0, "R3 R8 drain all");

    // FIFO order
    access(1, 1, 2'd0, 1, pk(16'h11, 3), "R5 push a");
    access(1, 1, 2'd0, 1, pk(16'h22, 3), "R5 push b");
    access(1, 1, 2'd0, 1, pk(16'h33, 3), "R5 push c");
    access(1, 0, 2'd2, 3, 0, "R5 pop a");
    access(1, 0, 2'd2, 3, 0, "R5 R8 pop b irq held");
    access(1, 0, 2'd2, 3, 0, "R5 R8 pop c");

    // overflow
    for (int k = 1; k <= DP; k++) access(1, 1, 2'd0, 2, pk(k + 40, 0), "R9 fill");
    access(1, 1, 2'd0, 2, pk(99, 0), "R9 drop when full");
    access(1, 1, 2'd1, 2, pk(98, 0), "R9 R3 others no overflow");
    access(1, 0, 2'd3, 0, 0, "R9 R10 overflow flag read");
    access(1, 1, 2'd3, 0, 32'hFFFF_FFFE, "R10 clear other bits");
    access(1, 0, 2'd3, 0, 0, "R10 bit 0 kept");
    for (int k = 0; k <= DP; k++) access(1, 0, 2'd2, 0, 0, "R9 order kept");
    access(1, 1, 2'd3, 0, 32'h1, "R10 clear bit 0");
    access(1, 0, 2'd3, 0, 0, "R10 cleared");
    for (int c = 1; c < NC; c++) access(1, 0, 2'd2, c, 0, "R6 drain");

    // flush
    access(1, 1, 2'd0, 0, pk(3, 1), "R7 push core 1");
    access(1, 1, 2'd0, 0, pk(4, 1), "R7 push core 1");
    access(1, 1, 2'd0, 0, pk(6, 2), "R7 push core 2");
    access(1, 1, 2'd2, 1, 32'hDEAD_BEEF, "R7 R8 flush core 1");
    access(1, 0, 2'd2, 1, 0, "R7 R6 flushed reads 0");
    access(1, 0, 2'd2, 2, 0, "R7 core 2 kept");
    access(0, 0, 2'd0, 0, 0, "R11 final idle");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule